// File: doc/BRIEF.md
# Logic analyzer command receiver

This block sits between a host serial byte link and the control registers of a logic analyzer core. Each received byte arrives as a one-cycle valid pulse with its data. The block splits the stream into commands. A byte with bit 7 clear is a one-byte command and acts at once. A byte with bit 7 set opens a long command. The next four bytes are that command's argument, least significant byte first. When the last argument byte arrives, the block issues a single write strobe that carries the opcode and the assembled 32-bit word.

Four one-byte commands are recognised: reset, run, metadata request and identify. Reset, run and metadata request each produce a one-cycle pulse for the core. Identify makes the block send a fixed four-byte signature on a transmit byte interface that uses a valid/ready handshake.

The framer only counts bytes. The class of the opening opcode sets how many bytes follow, so a run of five zero bytes always finishes any long command in progress and ends in the idle state. A host can therefore resynchronise without knowing where the block stands in the stream.

Top module: `la_cmd_rx`

## Requirements
- R1: While rstN is low, and after it is released, txValid, cmdValid, softReset, runPulse and metaReq are 0.
- R2: A byte with bit 7 set, received while idle, opens a long command. The next four received bytes are its argument, with the first of them in cmdArg[7:0] and the last in cmdArg[31:24]. In the cycle after the fourth argument byte, cmdValid is 1 for exactly one cycle, with cmdOpcode equal to the opening byte.
- R3: Argument bytes of a long command are never decoded as one-byte commands. Values 0x00, 0x01, 0x02 and 0x04 inside an argument cause no pulse and no transmission.
- R4: Byte 0x00 received while idle pulses softReset for one cycle, in the cycle after the byte. The fifth of any five consecutive 0x00 bytes always produces such a pulse, whatever position the framer held before the run.
- R5: Byte 0x02 received while idle, with no response in progress, transmits the bytes 0x31, 0x41, 0x4C, 0x53 in that order. Each byte is offered with txValid = 1 until it is taken with txReady = 1.
- R6: While txValid is 1 and txReady is 0, txData holds its value and txValid stays 1 in the next cycle, unless softReset is pulsed in that cycle.
- R7: Byte 0x01 received while idle pulses runPulse for one cycle. Byte 0x04 received while idle pulses metaReq for one cycle. Both pulses come in the cycle after the byte.
- R8: Any other byte with bit 7 clear, received while idle, has no effect on any output.
- R9: Byte 0x02 received while a response is still in progress is ignored. The response in progress completes with exactly four bytes.
- R10: A reset command cancels any response in progress: txValid is 0 in the cycle softReset is 1 and stays 0 afterwards until a new identify arrives.
- R11: At most one of cmdValid, softReset, runPulse and metaReq is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | A received byte is present this cycle |
| rxData | input | 8 | Received byte |
| txReady | input | 1 | Transmit side takes the offered byte |
| txValid | output | 1 | A response byte is offered |
| txData | output | 8 | Offered response byte |
| cmdValid | output | 1 | One-cycle strobe for a completed long command |
| cmdOpcode | output | 8 | Opcode of the completed long command |
| cmdArg | output | 32 | Argument of the completed long command |
| softReset | output | 1 | One-cycle pulse on a reset command |
| runPulse | output | 1 | One-cycle pulse on a run command |
| metaReq | output | 1 | One-cycle pulse on a metadata request |

## Verification
Long commands are tried with distinct bytes in every argument position, which catches byte-order errors. They are also tried with arguments made of one-byte opcode values, which separates argument collection from decoding. Runs of five zeros are sent from idle, from just after an opening opcode and from part-way through an argument, and each run must end in a reset pulse. Identify is tried with the transmit side always ready, alternating and stalled. The stalled case separates correct hold and ordering from skipped or repeated bytes, and also checks that a second identify is ignored and that a reset cancels the response.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;

  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_IDENT = 8'h02;
  localparam logic [7:0] OP_META  = 8'h04;

  // strobes from the framing control to the datapath
  typedef struct packed {
    logic loadOp;
    logic shiftArg;
    logic fire;
    logic doReset;
    logic doRun;
    logic doMeta;
  } strobe_t;

endpackage

// File: rtl/la_cmd_rx_ctrl.sv
module la_cmd_rx_ctrl
  import la_cmd_pkg::*;
#(
  parameter int ARG_BYTES = 4,
  parameter int SIG_BYTES = 4,
  localparam int CW = $clog2(ARG_BYTES + 1),
  localparam int IW = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxValid,
  input  logic [7:0]    rxData,
  input  logic          txReady,
  output strobe_t       stb,
  output logic          txBusy,
  output logic [IW-1:0] txIdx
);

  localparam logic [CW-1:0] ARG_LOAD = CW'(ARG_BYTES);
  localparam logic [IW-1:0] IDX_LAST = IW'(SIG_BYTES - 1);

  logic [CW-1:0] argLeft, nextLeft;
  logic          isIdle, identStart, txStep;

  assign isIdle = (argLeft == '0);

  always_comb begin
    stb      = '0;
    nextLeft = argLeft;
    if (rxValid) begin
      if (isIdle) begin
        if (rxData[7]) begin
          stb.loadOp = 1'b1;
          nextLeft   = ARG_LOAD;
        end else begin
          case (rxData)
            OP_RESET: stb.doReset = 1'b1;
            OP_RUN:   stb.doRun   = 1'b1;
            OP_META:  stb.doMeta  = 1'b1;
            default:  ;
          endcase
        end
      end else begin
        stb.shiftArg = 1'b1;
        nextLeft     = argLeft - CW'(1);
        if (argLeft == CW'(1)) stb.fire = 1'b1;
      end
    end
  end

  assign identStart = rxValid && isIdle && (rxData == OP_IDENT) && !txBusy;
  assign txStep     = txBusy && txReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      argLeft <= '0;
      txBusy  <= 1'b0;
      txIdx   <= '0;
    end else begin
      argLeft <= nextLeft;
      if (stb.doReset) begin
        txBusy <= 1'b0;
        txIdx  <= '0;
      end else if (identStart) begin
        txBusy <= 1'b1;
        txIdx  <= '0;
      end else if (txStep) begin
        if (txIdx == IDX_LAST) begin
          txBusy <= 1'b0;
          txIdx  <= '0;
        end else begin
          txIdx <= txIdx + IW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/la_cmd_rx_dp.sv
module la_cmd_rx_dp
  import la_cmd_pkg::*;
#(
  parameter int ARG_BYTES = 4,
  parameter int SIG_BYTES = 4,
  parameter logic [8*SIG_BYTES-1:0] SIG = 32'h534C_4131,
  localparam int AW = 8 * ARG_BYTES,
  localparam int IW = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    rxData,
  input  strobe_t       stb,
  input  logic [IW-1:0] txIdx,
  output logic          cmdValid,
  output logic [7:0]    cmdOpcode,
  output logic [AW-1:0] cmdArg,
  output logic          softReset,
  output logic          runPulse,
  output logic          metaReq,
  output logic [7:0]    txData
);

  logic [AW-1:0] argNext;

  generate
    if (ARG_BYTES > 1) begin : g_shift
      assign argNext = {rxData, cmdArg[AW-1:8]};
    end else begin : g_single
      assign argNext = rxData;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOpcode <= '0;
      cmdArg    <= '0;
      cmdValid  <= 1'b0;
      softReset <= 1'b0;
      runPulse  <= 1'b0;
      metaReq   <= 1'b0;
    end else begin
      if (stb.loadOp)   cmdOpcode <= rxData;
      if (stb.shiftArg) cmdArg    <= argNext;
      cmdValid  <= stb.fire;
      softReset <= stb.doReset;
      runPulse  <= stb.doRun;
      metaReq   <= stb.doMeta;
    end
  end

  assign txData = SIG[{txIdx, 3'b000} +: 8];

endmodule

// File: rtl/la_cmd_rx.sv
module la_cmd_rx
  import la_cmd_pkg::*;
#(
  parameter int ARG_BYTES = 4,
  parameter int SIG_BYTES = 4,
  parameter logic [8*SIG_BYTES-1:0] SIG = 32'h534C_4131,
  localparam int AW = 8 * ARG_BYTES,
  localparam int IW = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxValid,
  input  logic [7:0]    rxData,
  input  logic          txReady,
  output logic          txValid,
  output logic [7:0]    txData,
  output logic          cmdValid,
  output logic [7:0]    cmdOpcode,
  output logic [AW-1:0] cmdArg,
  output logic          softReset,
  output logic          runPulse,
  output logic          metaReq
);

  strobe_t       stb;
  logic          txBusy;
  logic [IW-1:0] txIdx;

  la_cmd_rx_ctrl #(.ARG_BYTES(ARG_BYTES), .SIG_BYTES(SIG_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .txReady(txReady), .stb(stb), .txBusy(txBusy), .txIdx(txIdx)
  );

  la_cmd_rx_dp #(.ARG_BYTES(ARG_BYTES), .SIG_BYTES(SIG_BYTES), .SIG(SIG)) u_dp (
    .clk(clk), .rstN(rstN), .rxData(rxData), .stb(stb), .txIdx(txIdx),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdArg(cmdArg),
    .softReset(softReset), .runPulse(runPulse), .metaReq(metaReq),
    .txData(txData)
  );

  assign txValid = txBusy;

endmodule

// File: rtl/la_cmd_rx_chk.sv
module la_cmd_rx_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          rxValid,
  input logic [7:0]    rxData,
  input logic          txReady,
  input logic          txValid,
  input logic [7:0]    txData,
  input logic          cmdValid,
  input logic [7:0]    cmdOpcode,
  input logic [AW-1:0] cmdArg,
  input logic          softReset,
  input logic          runPulse,
  input logic          metaReq
);

  logic [2:0] zeroRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zeroRun <= '0;
    else if (rxValid) begin
      if (rxData != 8'h00) zeroRun <= '0;
      else if (zeroRun != 3'd5) zeroRun <= zeroRun + 3'd1;
    end
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, softReset, runPulse, metaReq}));

  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (softReset || (txValid && $stable(txData))));

  // R10
  cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    softReset |-> !txValid);

  // R4
  five_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxData == 8'h00 && zeroRun >= 3'd4) |=> softReset);

endmodule

bind la_cmd_rx la_cmd_rx_chk #(.AW(8 * ARG_BYTES)) u_chk (.*);

// File: tb/la_cmd_rx_bench.sv
module la_cmd_rx_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        txReady = 1'b0;
  logic        txValid, cmdValid, softReset, runPulse, metaReq;
  logic [7:0]  txData, cmdOpcode;
  logic [31:0] cmdArg;

  int total = 0;
  int bad = 0;
  int eventsSeen = 0;
  int readyMode = 0;
  bit done = 0;

  // strobe items: {kind, opcode, arg}; kind 0 cmd, 1 reset, 2 run, 3 meta
  logic [42:0] evQ[$];
  logic [7:0]  txQ[$];

  int          modelLeft = 0;
  logic [7:0]  modelOp;
  logic [31:0] modelArg;

  always #2 clk = ~clk;

  la_cmd_rx u_la_cmd_rx (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .txReady(txReady), .txValid(txValid), .txData(txData),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdArg(cmdArg),
    .softReset(softReset), .runPulse(runPulse), .metaReq(metaReq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one byte per call, model pushes expected results
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxData  = b;
    if (modelLeft == 0) begin
      if (b[7]) begin
        modelOp = b; modelLeft = 4; modelArg = '0;
      end else if (b == 8'h00) begin
        evQ.push_back({3'd1, 40'd0});
        txQ.delete();
      end else if (b == 8'h01) evQ.push_back({3'd2, 40'd0});
      else if (b == 8'h04) evQ.push_back({3'd3, 40'd0});
      else if (b == 8'h02 && txQ.size() == 0) begin
        txQ.push_back(8'h31); txQ.push_back(8'h41);
        txQ.push_back(8'h4C); txQ.push_back(8'h53);
      end
    end else begin
      modelArg  = {b, modelArg[31:8]};
      modelLeft = modelLeft - 1;
      if (modelLeft == 0) evQ.push_back({3'd0, modelOp, modelArg});
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b0;
    end
  endtask

  task automatic drain;
    int guard;
    guard = 0;
    while ((txQ.size() != 0 || txValid) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    idle(3);
  endtask

  // ready pattern: 0 low, 1 high, 2 alternating
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph++;
      txReady = (readyMode == 1) || (readyMode == 2 && ph[0]);
    end
  end

  // monitor
  initial begin
    logic [42:0] obs, expv;
    forever begin
      @(negedge clk);
      if (rstN) begin
        for (int k = 0; k < 4; k++) begin
          bit hit;
          hit = 0;
          case (k)
            0: if (cmdValid)  begin hit = 1; obs = {3'd0, cmdOpcode, cmdArg}; end
            1: if (softReset) begin hit = 1; obs = {3'd1, 40'd0}; end
            2: if (runPulse)  begin hit = 1; obs = {3'd2, 40'd0}; end
            default: if (metaReq) begin hit = 1; obs = {3'd3, 40'd0}; end
          endcase
          if (hit) begin
            eventsSeen++;
            if (evQ.size() == 0) check(0, "R2/R3/R7/R8 unexpected strobe", 64'(obs), 64'd0);
            else begin
              expv = evQ.pop_front();
              check(obs == expv, "R2/R4/R7 strobe", 64'(obs), 64'(expv));
            end
          end
        end
        if (txValid && txReady) begin
          eventsSeen++;
          if (txQ.size() == 0) check(0, "R5/R9/R10 unexpected tx byte", 64'(txData), 64'd0);
          else begin
            logic [7:0] e;
            e = txQ.pop_front();
            check(txData == e, "R5 tx byte order", 64'(txData), 64'(e));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    // R1 during reset
    check({txValid, cmdValid, softReset, runPulse, metaReq} == 5'b0, "R1 reset",
          64'({txValid, cmdValid, softReset, runPulse, metaReq}), 64'd0);
    rstN = 1'b1;
    idle(2);
    check({txValid, cmdValid, softReset, runPulse, metaReq} == 5'b0, "R1 after release",
          64'({txValid, cmdValid, softReset, runPulse, metaReq}), 64'd0);

    // R2 distinct argument bytes, back to back
    sendByte(8'h81); sendByte(8'h78); sendByte(8'h56); sendByte(8'h34); sendByte(8'h12);
    idle(3);
    // R3 argument made of one-byte opcode values, with gaps
    sendByte(8'hC0); idle(1); sendByte(8'h00); sendByte(8'h02); idle(2);
    sendByte(8'h01); sendByte(8'h04);
    idle(3);
    check(txValid == 1'b0, "R3 no tx from argument", 64'(txValid), 64'd0);

    // R7 run and metadata request
    sendByte(8'h01); idle(1); sendByte(8'h04);
    idle(3);

    // R8 ignored short opcodes
    snap = eventsSeen;
    sendByte(8'h11); sendByte(8'h7F); sendByte(8'h03);
    idle(4);
    check(eventsSeen == snap && !txValid, "R8 ignored opcodes", 64'(eventsSeen), 64'(snap));

    // R5 identify with alternating ready
    readyMode = 2;
    sendByte(8'h02);
    idle(1);
    drain();
    check(txQ.size() == 0, "R5 response complete", 64'(txQ.size()), 64'd0);

    // R9 identify while stalled response pending, R6 hold
    readyMode = 0;
    sendByte(8'h02); idle(2);
    sendByte(8'h02); idle(4);
    check(txValid && txData == 8'h31, "R6 stalled first byte",
          64'({txValid, txData}), 64'h131);
    readyMode = 1;
    drain();
    check(txQ.size() == 0 && !txValid, "R9 exactly four bytes", 64'(txQ.size()), 64'd0);

    // R10 reset cancels a pending response
    readyMode = 0;
    sendByte(8'h02); idle(3);
    check(txValid == 1'b1, "R5 response offered", 64'(txValid), 64'd1);
    sendByte(8'h00);
    idle(1);
    check(txValid == 1'b0, "R10 cancel", 64'(txValid), 64'd0);
    readyMode = 1;
    idle(6);
    check(txValid == 1'b0, "R10 stays cancelled", 64'(txValid), 64'd0);

    // R4 resync from several framer positions
    sendByte(8'h85); sendByte(8'h11);
    for (int i = 0; i < 5; i++) sendByte(8'h00);
    idle(3);
    sendByte(8'h9A);
    for (int i = 0; i < 5; i++) sendByte(8'h00);
    idle(3);
    sendByte(8'hFF); sendByte(8'hAA); sendByte(8'hBB); idle(2);
    for (int i = 0; i < 5; i++) begin sendByte(8'h00); idle(1); end
    idle(3);
    for (int i = 0; i < 5; i++) sendByte(8'h00);
    idle(3);
    // framer idle after the run: a run command decodes directly
    sendByte(8'h01);
    idle(3);

    check(evQ.size() == 0, "R2/R4/R7 all strobes seen", 64'(evQ.size()), 64'd0);
    check(txQ.size() == 0, "R5 all tx bytes seen", 64'(txQ.size()), 64'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule